// File: doc/BRIEF.md
# TDM Switch Output Stage

This block builds the eight serial output streams of a time-slot switch. Each stream carries 32 eight-bit channels per frame. For every output channel the block reads two connection memories that sit outside it: a low memory with one byte per entry and a high memory with three control bits per entry. It then either forwards a byte from the received-data memory, using the low byte as that memory's address, or sends the low byte itself as a fixed message. Each stream has its own data signal and its own drive-enable signal, so the pad ring can build the three-state pins.

A frame timing block supplies a one-cycle bit-cell strobe together with the channel number and bit number of the cell that begins. The block fetches the settings and data for channel c+2 while channel c goes out. It stages the result in two steps. A control bit per entry is sent on a separate serial line one channel ahead of the data it belongs to. An output-drive-enable input and a broadcast-message input act on every channel at once.

Top module: `tsi_out_stage`

## Requirements
- R1: A channel in switched mode sends, on every stream, the data-memory byte whose address is that channel's low byte. The low byte holds the source stream in bits 7-5 and the source channel in bits 4-0. The byte goes out most significant bit first: the cell with bit number k carries byte bit 7-k. The outputs for a cell appear in the cycle after the `cell_go` that announces it.
- R2: When bit 2 of a channel's high entry is 1, the channel sends its low byte unchanged in every frame until the memory content changes.
- R3: When `ode` is 1 and broadcast is off, bit 0 of the high entry sets `tx_oe` for that stream and channel: 1 drives and 0 releases. The enable changes only at channel starts.
- R4: When `ode` is 0, every bit of `tx_oe` is 0 in the same cycle, whatever the memories hold.
- R5: When `bcast_msg` is 1, every channel acts as if high bits 2 and 0 were both 1: it sends the low byte and drives. The setting is sampled when the channel's settings are fetched, two channels before the channel goes out.
- R6: `ctl_out` sends bit 1 of the high entries for channel c+1 during data channel c. Cell k of that channel carries the bit for stream k.
- R7: While `rst` is 1, `tx_oe` is all 0. In the first cycle after reset, `tx_oe` is still all 0 and `ctl_out` is 0.
- R8: The data memory is read only for switched channels, exactly one cycle after the connection read for the same stream. With everything switched there are 8 data reads per channel, and with everything in message mode there are none. All reads return data one cycle after the request, and each bit cell must last at least 2 clock cycles.
- R9: Connection reads use the address {stream[2:0], channel[4:0]}. The eight streams of one channel are read in consecutive cycles, stream 0 first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cell_go | input | 1 | One-cycle strobe: a bit cell begins |
| cell_chan | input | 5 | Channel number of the beginning cell |
| cell_bit | input | 3 | Bit number (0 = first, sends byte bit 7) |
| ode | input | 1 | Global output drive enable |
| bcast_msg | input | 1 | Force every channel into message mode and drive |
| cm_rd | output | 1 | Connection memory read request |
| cm_addr | output | 8 | Connection memory address {stream, channel} |
| cm_lo | input | 8 | Low connection byte, one cycle after request |
| cm_hi | input | 3 | High bits: 2 message, 1 control, 0 drive |
| dm_rd | output | 1 | Data memory read request |
| dm_addr | output | 8 | Data memory address |
| dm_data | input | 8 | Data memory byte, one cycle after request |
| tx_dat | output | 8 | Serial data, one bit per stream |
| tx_oe | output | 8 | Drive enable, one bit per stream |
| ctl_out | output | 1 | Serial control bit stream |

## Verification
The assertions check on every cycle that a data read always follows a connection read, and that the connection address steps through the streams in order within a channel. They also check that data and control outputs move only on cell strobes, that drive enables move only at channel starts or on a change of `ode`, and that the outputs come out of reset released. The scenarios alone show the values themselves: switched bytes from any source slot including the top corner, message bytes, per-channel release, the `ode` and broadcast overrides, the one-channel lead of the control stream, and the read counts per frame.

// File: rtl/tsi_pkg.sv
`timescale 1ns/1ps
package tsi_pkg;
    localparam int unsigned NSTR  = 8;            // streams (also cells per channel)
    localparam int unsigned NCHAN = 32;           // channels per frame
    localparam int unsigned BW    = 8;            // bits per channel
    localparam int unsigned SW    = $clog2(NSTR);
    localparam int unsigned CW    = $clog2(NCHAN);
    localparam int unsigned BIW   = $clog2(BW);
    localparam int unsigned AW    = SW + CW;      // equals BW: low byte is an address
    localparam int unsigned HW    = 3;            // high entry width
    localparam int unsigned LEAD  = 2;            // channels fetched ahead

    localparam int unsigned HB_DRV = 0;
    localparam int unsigned HB_CTL = 1;
    localparam int unsigned HB_MSG = 2;

    typedef struct packed {
        logic [BW-1:0] octet;
        logic          drive;
        logic          ctl;
    } slot_t;

    function automatic logic [CW-1:0] chan_ahead(input logic [CW-1:0] c);
        return c + CW'(LEAD);
    endfunction
endpackage

// File: rtl/tsi_fetch.sv
`timescale 1ns/1ps
module tsi_fetch
    import tsi_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] start_chan,
    input  logic          bcast,
    output logic          cm_rd,
    output logic [AW-1:0] cm_addr,
    input  logic [BW-1:0] cm_lo,
    input  logic [HW-1:0] cm_hi,
    output logic          dm_rd,
    output logic [AW-1:0] dm_addr,
    input  logic [BW-1:0] dm_data,
    output logic          wr_en,
    output logic [SW-1:0] wr_idx,
    output slot_t         wr_slot
);
    logic          busy;
    logic [SW-1:0] cnt;
    logic [CW-1:0] tgt;

    logic          p1_v;
    logic [SW-1:0] p1_s;

    logic          p2_v;
    logic [SW-1:0] p2_s;
    logic          p2_msg, p2_drv, p2_ctl;
    logic [BW-1:0] p2_lo;

    logic msg_now, drv_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
            tgt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
            tgt  <= chan_ahead(start_chan);
        end else if (busy) begin
            cnt <= cnt + 1'b1;
            if (cnt == SW'(NSTR - 1)) busy <= 1'b0;
        end
    end

    assign cm_rd   = busy;
    assign cm_addr = {cnt, tgt};

    assign msg_now = bcast | cm_hi[HB_MSG];
    assign drv_now = bcast | cm_hi[HB_DRV];
    assign dm_rd   = p1_v & ~msg_now;
    assign dm_addr = cm_lo;

    always_ff @(posedge clk) begin
        if (rst) begin
            p1_v   <= 1'b0;
            p1_s   <= '0;
            p2_v   <= 1'b0;
            p2_s   <= '0;
            p2_msg <= 1'b0;
            p2_drv <= 1'b0;
            p2_ctl <= 1'b0;
            p2_lo  <= '0;
        end else begin
            p1_v   <= cm_rd;
            p1_s   <= cnt;
            p2_v   <= p1_v;
            p2_s   <= p1_s;
            p2_msg <= msg_now;
            p2_drv <= drv_now;
            p2_ctl <= cm_hi[HB_CTL];
            p2_lo  <= cm_lo;
        end
    end

    assign wr_en         = p2_v;
    assign wr_idx        = p2_s;
    assign wr_slot.octet = p2_msg ? p2_lo : dm_data;
    assign wr_slot.drive = p2_drv;
    assign wr_slot.ctl   = p2_ctl;
endmodule

// File: rtl/tsi_lane.sv
`timescale 1ns/1ps
module tsi_lane
    import tsi_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           cell_go,
    input  logic           ch_go,
    input  logic [BIW-1:0] cell_bit,
    input  slot_t          stage_in,
    output logic           sd,
    output logic           drv
);
    localparam logic [BIW-1:0] TOPB = BIW'(BW - 1);

    slot_t nxt, cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            nxt <= '0;
            cur <= '0;
            sd  <= 1'b0;
        end else if (cell_go) begin
            if (ch_go) begin
                cur <= nxt;
                nxt <= stage_in;
                sd  <= nxt.octet[TOPB];
            end else begin
                sd  <= cur.octet[TOPB - cell_bit];
            end
        end
    end

    assign drv = cur.drive;
endmodule

// File: rtl/tsi_ctl_tx.sv
`timescale 1ns/1ps
module tsi_ctl_tx
    import tsi_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            cell_go,
    input  logic            ch_go,
    input  logic [BIW-1:0]  cell_bit,
    input  logic [NSTR-1:0] ctl_vec,
    output logic            ctl_out
);
    logic [NSTR-1:0] held;

    always_ff @(posedge clk) begin
        if (rst) begin
            held    <= '0;
            ctl_out <= 1'b0;
        end else if (cell_go) begin
            if (ch_go) begin
                held    <= ctl_vec;
                ctl_out <= ctl_vec[0];
            end else begin
                ctl_out <= held[cell_bit];
            end
        end
    end
endmodule

// File: rtl/tsi_out_stage.sv
`timescale 1ns/1ps
module tsi_out_stage
    import tsi_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            cell_go,
    input  logic [CW-1:0]   cell_chan,
    input  logic [BIW-1:0]  cell_bit,
    input  logic            ode,
    input  logic            bcast_msg,
    output logic            cm_rd,
    output logic [AW-1:0]   cm_addr,
    input  logic [BW-1:0]   cm_lo,
    input  logic [HW-1:0]   cm_hi,
    output logic            dm_rd,
    output logic [AW-1:0]   dm_addr,
    input  logic [BW-1:0]   dm_data,
    output logic [NSTR-1:0] tx_dat,
    output logic [NSTR-1:0] tx_oe,
    output logic            ctl_out
);
    logic            ch_go;
    logic            wr_en;
    logic [SW-1:0]   wr_idx;
    slot_t           wr_slot;
    slot_t           stg [NSTR];
    logic [NSTR-1:0] ctl_vec;
    logic [NSTR-1:0] lane_drv;

    assign ch_go = cell_go && (cell_bit == '0);

    tsi_fetch u_fetch (
        .clk        (clk),
        .rst        (rst),
        .start      (ch_go),
        .start_chan (cell_chan),
        .bcast      (bcast_msg),
        .cm_rd      (cm_rd),
        .cm_addr    (cm_addr),
        .cm_lo      (cm_lo),
        .cm_hi      (cm_hi),
        .dm_rd      (dm_rd),
        .dm_addr    (dm_addr),
        .dm_data    (dm_data),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_slot    (wr_slot)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NSTR; i++) stg[i] <= '0;
        end else if (wr_en) begin
            stg[wr_idx] <= wr_slot;
        end
    end

    for (genvar s = 0; s < NSTR; s++) begin : g_lane
        assign ctl_vec[s] = stg[s].ctl;

        tsi_lane u_lane (
            .clk      (clk),
            .rst      (rst),
            .cell_go  (cell_go),
            .ch_go    (ch_go),
            .cell_bit (cell_bit),
            .stage_in (stg[s]),
            .sd       (tx_dat[s]),
            .drv      (lane_drv[s])
        );

        assign tx_oe[s] = lane_drv[s] & ode & ~rst;
    end

    tsi_ctl_tx u_ctl (
        .clk      (clk),
        .rst      (rst),
        .cell_go  (cell_go),
        .ch_go    (ch_go),
        .cell_bit (cell_bit),
        .ctl_vec  (ctl_vec),
        .ctl_out  (ctl_out)
    );
endmodule

// File: rtl/tsi_out_stage_chk.sv
`timescale 1ns/1ps
module tsi_out_stage_chk
    import tsi_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            cell_go,
    input logic [BIW-1:0]  cell_bit,
    input logic            ode,
    input logic            cm_rd,
    input logic [AW-1:0]   cm_addr,
    input logic            dm_rd,
    input logic [NSTR-1:0] tx_dat,
    input logic [NSTR-1:0] tx_oe,
    input logic            ctl_out
);
    // R8
    dm_after_cm_chk: assert property (@(posedge clk) disable iff (rst)
        dm_rd |-> $past(cm_rd));

    // R9
    cm_stream_step_chk: assert property (@(posedge clk) disable iff (rst)
        (cm_rd && $past(cm_rd)) |->
            (cm_addr[AW-1:CW] == SW'($past(cm_addr[AW-1:CW]) + 1'b1)) &&
            (cm_addr[CW-1:0] == $past(cm_addr[CW-1:0])));

    // R1
    dat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(cell_go) |-> $stable(tx_dat));

    // R6
    ctl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(cell_go) |-> $stable(ctl_out));

    // R3
    oe_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(cell_go && cell_bit == '0) && $stable(ode) && !$past(rst))
            |-> $stable(tx_oe));

    // R7
    oe_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (tx_oe == '0) && (ctl_out == 1'b0));
endmodule

bind tsi_out_stage tsi_out_stage_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cell_go  (cell_go),
    .cell_bit (cell_bit),
    .ode      (ode),
    .cm_rd    (cm_rd),
    .cm_addr  (cm_addr),
    .dm_rd    (dm_rd),
    .tx_dat   (tx_dat),
    .tx_oe    (tx_oe),
    .ctl_out  (ctl_out)
);

// File: tb/tsi_out_stage_tb.sv
`timescale 1ns/1ps
module tsi_out_stage_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cell_go = 1'b0;
    logic [4:0] cell_chan = '0;
    logic [2:0] cell_bit = '0;
    logic       ode = 1'b1;
    logic       bcast_msg = 1'b0;
    logic       cm_rd, dm_rd;
    logic [7:0] cm_addr, dm_addr;
    logic [7:0] cm_lo, dm_data;
    logic [2:0] cm_hi;
    logic [7:0] tx_dat, tx_oe;
    logic       ctl_out;

    logic [7:0] lo_mem [256];
    logic [2:0] hi_mem [256];
    logic [7:0] dm_mem [256];
    int dm_cnt = 0;

    int total = 0;
    int bad = 0;
    bit chk_on = 1'b0;
    bit finished = 1'b0;
    string dtag = "R1";
    string otag = "R3";

    always #2 clk = ~clk;

    tsi_out_stage u_dut (
        .clk(clk), .rst(rst), .cell_go(cell_go), .cell_chan(cell_chan),
        .cell_bit(cell_bit), .ode(ode), .bcast_msg(bcast_msg),
        .cm_rd(cm_rd), .cm_addr(cm_addr), .cm_lo(cm_lo), .cm_hi(cm_hi),
        .dm_rd(dm_rd), .dm_addr(dm_addr), .dm_data(dm_data),
        .tx_dat(tx_dat), .tx_oe(tx_oe), .ctl_out(ctl_out)
    );

    // memory models: registered read, one cycle latency
    always @(posedge clk) begin
        if (cm_rd) begin
            cm_lo <= lo_mem[cm_addr];
            cm_hi <= hi_mem[cm_addr];
        end
        if (dm_rd) begin
            dm_data <= dm_mem[dm_addr];
            dm_cnt  <= dm_cnt + 1;
        end
    end

    function automatic logic [7:0] exp_octet(input int s, input int c);
        logic [7:0] a;
        logic       m;
        a = {s[2:0], c[4:0]};
        m = bcast_msg | hi_mem[a][2];
        return m ? lo_mem[a] : dm_mem[lo_mem[a]];
    endfunction

    function automatic logic [7:0] exp_oe(input int c);
        logic [7:0] r;
        for (int s = 0; s < 8; s++)
            r[s] = ode & (bcast_msg | hi_mem[{s[2:0], c[4:0]}][0]);
        return r;
    endfunction

    function automatic logic exp_ctl(input int c, input int b);
        logic [4:0] nc;
        nc = 5'(c + 1);
        return hi_mem[{b[2:0], nc}][1];
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_cell(input int c, input int b);
        logic [7:0] ed;
        for (int s = 0; s < 8; s++) ed[s] = exp_octet(s, c)[7 - b];
        check({dtag, " data"}, tx_dat, ed);              // R1,R9 / R2 / R5
        check({otag, " drive"}, tx_oe, exp_oe(c));        // R3 / R4 / R5
        check("R6 control", {7'd0, ctl_out}, {7'd0, exp_ctl(c, b)});
    endtask

    // timing generator: one cell every 2 cycles; checks the cell just started
    initial begin
        int tc = 0;
        int tb = 0;
        int pc = 0;
        int pb = 0;
        bit ph = 1'b0;
        bit pgo = 1'b0;
        forever begin
            @(negedge clk);
            if (pgo && chk_on && !rst) check_cell(pc, pb);
            if (ph) begin
                cell_go   = 1'b1;
                cell_chan = 5'(tc);
                cell_bit  = 3'(tb);
                pc = tc; pb = tb; pgo = 1'b1;
                tb++;
                if (tb == 8) begin tb = 0; tc = (tc + 1) % 32; end
            end else begin
                cell_go = 1'b0;
                pgo = 1'b0;
            end
            ph = ~ph;
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic window(input int cycles);
        repeat (80) @(negedge clk);
        chk_on = 1'b1;
        repeat (cycles) @(negedge clk);
        chk_on = 1'b0;
    endtask

    task automatic fill_random();
        for (int i = 0; i < 256; i++) begin
            lo_mem[i] = 8'($urandom);
            hi_mem[i] = 3'($urandom);
            dm_mem[i] = 8'($urandom);
        end
    endtask

    initial begin
        #400000;
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        int d0;
        void'($urandom(32'd4242));
        fill_random();

        // R7: outputs released during reset
        repeat (6) begin
            @(negedge clk);
            check("R7 reset drive", tx_oe, 8'h00);
            check("R7 reset control", {7'd0, ctl_out}, 8'h00);
        end
        rst = 1'b0;

        // random mix of modes, sources and enables
        dtag = "R1"; otag = "R3";
        window(1024);

        // top corner source slot: stream 7 channel 31, all switched and driven
        for (int i = 0; i < 256; i++) begin
            hi_mem[i] = 3'b011;
            lo_mem[i] = (i % 3 == 0) ? 8'hFF : 8'($urandom);
        end
        dm_mem[255] = 8'hA5;
        repeat (80) @(negedge clk);
        d0 = dm_cnt;
        repeat (512) @(negedge clk);
        check("R8 switched reads per frame", 8'(dm_cnt - d0), 8'(256));
        window(512);

        // message mode on every entry, no data reads
        dtag = "R2";
        for (int i = 0; i < 256; i++) hi_mem[i] = 3'b101;
        repeat (80) @(negedge clk);
        d0 = dm_cnt;
        repeat (512) @(negedge clk);
        check("R8 message reads per frame", 8'(dm_cnt - d0), 8'(0));
        window(512);

        // all channels released, control bits alternating
        dtag = "R1"; otag = "R3";
        for (int i = 0; i < 256; i++) hi_mem[i] = (i % 2 == 1) ? 3'b010 : 3'b000;
        window(512);

        // global drive enable low
        fill_random();
        otag = "R4";
        ode = 1'b0;
        window(512);
        ode = 1'b1;

        // broadcast message override over entries that say switched and released
        dtag = "R5"; otag = "R5";
        for (int i = 0; i < 256; i++) hi_mem[i] = 3'($urandom) & 3'b010;
        bcast_msg = 1'b1;
        window(512);
        bcast_msg = 1'b0;

        // final random pass
        dtag = "R1"; otag = "R3";
        fill_random();
        window(512);

        finish_run();
    end
endmodule